// File: doc/BRIEF.md
# Device-Side Multiword DMA Request Handshake

This block sits at the storage-device end of a parallel, ATA-style multiword DMA link. Software or a command engine loads a transfer length and a direction with a one-cycle start pulse. The block then asks the host for one 16-bit word at a time through an active-low request line. It raises the request only when the local word FIFO can supply a word or accept one. It completes each word with the host's acknowledge and the host's read or write strobe, then asks again until the programmed word count is used up.

Host-side signals are treated as already synchronous to `clk`, and a synchronous reset is used. The request line is released to high impedance whenever the drive-select bit names the other device on the cable. A chip select seen while the host is acknowledging is a protocol violation, and it is latched in a sticky flag.

Top module: `mwdma_dev_req`

## Requirements
- R1: During and after a synchronous reset, `dmarq_n` is 1 while this device is selected. `dd_oe`, `done`, `proto_err`, `src_ready` and `snk_valid` are all 0.
- R2: The request (`dmarq_n`=0) is raised only while a transfer is open and the FIFO can serve it: `src_valid`=1 for a read (`start_rd`=1), or `snk_ready`=1 for a write. It goes low one clock after the condition is sampled true.
- R3: Once raised, the request stays low until `dmack_n` is sampled low. It returns high on the following clock.
- R4: For a read, while `dmack_n` and `ior_n` are low, `dd_oe` becomes 1 one clock later, and `dd_out` carries `src_data`. On the clock where `ior_n` is first sampled high again, `src_ready` pulses for one cycle and `dd_oe` drops.
- R5: For a write, on the clock where `iow_n` is first sampled high after being low with `dmack_n` low, `snk_valid` pulses for one cycle. `snk_data` equals the `dd_in` value sampled on the last clock where `iow_n` was low.
- R6: A strobe of the opposite direction, or a second strobe within the same acknowledge, moves no word. It produces no `src_ready` or `snk_valid` pulse and no `dd_oe`.
- R7: Each moved word decrements the remaining count. When the host releases `dmack_n` after the last word, `done` rises and no further request is raised. A start with length 0 sets `done` at once and never requests.
- R8: When `dmack_n` is released with words still remaining, the request is raised again as soon as the FIFO condition of R2 holds.
- R9: `proto_err` is set when `cs0_n` or `cs1_n` is low while `dmack_n` is low after the request was served. It stays set until the next accepted start. A chip select outside acknowledge does not set it.
- R10: When `drv_sel` differs from parameter `SEL_ID` (default 0), `dmarq_n` is high impedance. When it matches, `dmarq_n` is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Open a transfer (accepted only when idle) |
| start_rd | input | 1 | 1 = device-to-host, 0 = host-to-device |
| start_len | input | LEN_W | Words to move |
| drv_sel | input | 1 | Drive-select bit from the device register |
| dmack_n | input | 1 | Host DMA acknowledge, active low |
| ior_n | input | 1 | Host read strobe, active low |
| iow_n | input | 1 | Host write strobe, active low |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| dmarq_n | output | 1 | DMA request, active low, tristate |
| dd_in | input | DATA_W | Data bus value from host |
| dd_out | output | DATA_W | Data bus value to host |
| dd_oe | output | 1 | Data bus drive enable |
| src_data | input | DATA_W | FIFO head word for reads |
| src_valid | input | 1 | FIFO holds a word |
| src_ready | output | 1 | Pop FIFO head |
| snk_data | output | DATA_W | Word to push into FIFO |
| snk_valid | output | 1 | Push word |
| snk_ready | input | 1 | FIFO has a free slot |
| done | output | 1 | Programmed count completed |
| proto_err | output | 1 | Sticky chip-select-during-DMA flag |

## Verification
A write strobe's trailing edge and a chip-select violation can land on the same clock. The first pushes a word and decrements the count; the second sets the sticky error. The bench drives `cs0_n` low at the very edge where `iow_n` returns high. It then requires both outcomes on the next sample: one push carrying the earlier bus word, and `proto_err` set. A second overlap puts an opposite-direction strobe inside a write acknowledge. It is judged by the absence of any pop or bus drive.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_REQ,
        ST_ACK,
        ST_HOLD
    } hs_state_e;

    typedef struct packed {
        hs_state_e st;
        logic      rd;
        logic      req;
        logic      oe;
        logic      done;
        logic      err;
    } hs_ctl_s;

endpackage

// File: rtl/mwdma_strobe.sv
module mwdma_strobe (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    output logic trail
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strb_n;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= prev_d;
    end

    assign trail = !prev_q && strb_n;

endmodule

// File: rtl/mwdma_wordcnt.sv
module mwdma_wordcnt #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    input  logic             dec,
    output logic             zero
);
    logic [LEN_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load)     rem_d = len;
        else if (dec) rem_d = rem_q - LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) rem_q <= '0;
        else     rem_q <= rem_d;
    end

    assign zero = (rem_q == '0);

    // R7: a word is never counted past zero
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        dec |-> !zero);

endmodule

// File: rtl/mwdma_dev_req.sv
module mwdma_dev_req
    import mwdma_pkg::*;
#(
    parameter int   DATA_W = 16,
    parameter int   LEN_W  = 8,
    parameter logic SEL_ID = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_rd,
    input  logic [LEN_W-1:0]  start_len,
    input  logic              drv_sel,
    input  logic              dmack_n,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic              cs0_n,
    input  logic              cs1_n,
    output logic              dmarq_n,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    input  logic [DATA_W-1:0] src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [DATA_W-1:0] snk_data,
    output logic              snk_valid,
    input  logic              snk_ready,
    output logic              done,
    output logic              proto_err
);
    localparam int N_STRB = 2;

    hs_ctl_s           ctl_d, ctl_q;
    logic [DATA_W-1:0] word_d, word_q;

    logic [N_STRB-1:0] strb_n_w;
    logic [N_STRB-1:0] strb_trail;
    logic              go, have, acked, cs_seen, moved, cnt_zero;

    assign strb_n_w = {iow_n, ior_n};

    for (genvar g = 0; g < N_STRB; g++) begin : g_strb
        mwdma_strobe u_strb (
            .clk    (clk),
            .rst    (rst),
            .strb_n (strb_n_w[g]),
            .trail  (strb_trail[g])
        );
    end

    assign go      = start && (ctl_q.st == ST_IDLE);
    assign have    = ctl_q.rd ? src_valid : snk_ready;
    assign acked   = !dmack_n;
    assign cs_seen = !cs0_n || !cs1_n;
    assign moved   = (ctl_q.st == ST_ACK) && acked &&
                     (ctl_q.rd ? strb_trail[0] : strb_trail[1]);

    mwdma_wordcnt #(.LEN_W(LEN_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (go),
        .len  (start_len),
        .dec  (moved),
        .zero (cnt_zero)
    );

    always_comb begin
        ctl_d  = ctl_q;
        word_d = word_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (go) begin
                    ctl_d.rd   = start_rd;
                    ctl_d.err  = 1'b0;
                    ctl_d.done = (start_len == '0);
                    if (start_len != '0) ctl_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (have) ctl_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (acked) ctl_d.st = ST_ACK;
            end
            ST_ACK: begin
                if (!acked)     ctl_d.st = ST_WAIT;
                else if (moved) ctl_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (!acked) begin
                    if (cnt_zero) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = ST_WAIT;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase

        if (((ctl_q.st == ST_ACK) || (ctl_q.st == ST_HOLD)) && acked && cs_seen)
            ctl_d.err = 1'b1;

        if ((ctl_q.st == ST_ACK) && !ctl_q.rd && !iow_n)
            word_d = dd_in;

        ctl_d.req = (ctl_d.st == ST_REQ);
        ctl_d.oe  = (ctl_q.st == ST_ACK) && ctl_q.rd && acked && !ior_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{st: ST_IDLE, rd: 1'b0, req: 1'b0, oe: 1'b0,
                        done: 1'b0, err: 1'b0};
            word_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            word_q <= word_d;
        end
    end

    assign dmarq_n   = (drv_sel == SEL_ID) ? ~ctl_q.req : 1'bz;
    assign dd_out    = src_data;
    assign dd_oe     = ctl_q.oe;
    assign src_ready = moved && ctl_q.rd;
    assign snk_valid = moved && !ctl_q.rd;
    assign snk_data  = word_q;
    assign done      = ctl_q.done;
    assign proto_err = ctl_q.err;

    // R2: a request only rises when the FIFO could serve it
    p_req_needs_fifo_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.req) |-> $past(ctl_q.rd ? src_valid : snk_ready));

    // R3: the request drops only after an acknowledge was sampled
    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.req) |-> $past(!dmack_n));

    // R4: the bus is driven only after read strobe and acknowledge
    p_oe_gated_r4: assert property (@(posedge clk) disable iff (rst)
        ctl_q.oe |-> $past(!dmack_n && !ior_n));

    // R6: pop and push never coincide
    p_one_dir_r6: assert property (@(posedge clk) disable iff (rst)
        !(src_ready && snk_valid));

    // R7: a finished transfer does not request
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        ctl_q.done |-> !ctl_q.req);

    // R9: the error flag holds until a start is accepted
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.err && !(start && ctl_q.st == ST_IDLE)) |=> ctl_q.err);

endmodule

// File: tb/tb_mwdma_dev_req.sv
`timescale 1ns/1ps
module tb_mwdma_dev_req;
    localparam int DW = 16;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, start_rd = 1'b0;
    logic [LW-1:0] start_len = '0;
    logic drv_sel = 1'b0;
    logic dmack_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1, cs0_n = 1'b1, cs1_n = 1'b1;
    wire  dmarq_w;
    logic [DW-1:0] dd_in = '0;
    logic [DW-1:0] dd_out, snk_data;
    logic dd_oe, src_ready, snk_valid, done, proto_err;
    logic src_valid, snk_ready;
    logic src_gate = 1'b0, snk_gate = 1'b0;
    int   src_idx = 0, src_limit = 0, push_cnt = 0;
    logic [DW-1:0] last_push = '0;
    int   errors = 0, checks = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    pullup (dmarq_w);

    function automatic logic [DW-1:0] srcw(int k);
        return DW'((k * 32'h1357) ^ 32'hC0DE);
    endfunction

    assign src_valid = src_gate && (src_idx < src_limit);
    assign snk_ready = snk_gate;

    always @(posedge clk) begin
        if (src_ready) src_idx <= src_idx + 1;
        if (snk_valid) begin
            push_cnt  <= push_cnt + 1;
            last_push <= snk_data;
        end
    end

    mwdma_dev_req #(.DATA_W(DW), .LEN_W(LW), .SEL_ID(1'b0)) dut (
        .clk(clk), .rst(rst), .start(start), .start_rd(start_rd),
        .start_len(start_len), .drv_sel(drv_sel), .dmack_n(dmack_n),
        .ior_n(ior_n), .iow_n(iow_n), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .dmarq_n(dmarq_w), .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe),
        .src_data(srcw(src_idx)), .src_valid(src_valid), .src_ready(src_ready),
        .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
        .done(done), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic open_xfer(input bit rd, input int len);
        src_idx = 0; push_cnt = 0; src_limit = len;
        src_gate = 1'b0; snk_gate = 1'b0;
        @(negedge clk);
        start = 1'b1; start_rd = rd; start_len = LW'(len);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_req(input string tag);
        int n = 0;
        while (dmarq_w !== 1'b0 && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk(dmarq_w === 1'b0, tag, {31'b0, dmarq_w}, 0);
    endtask

    task automatic one_word(input bit rd, input int w, input int ackd, input bit extra);
        for (int i = 0; i < ackd; i++) begin
            @(negedge clk);
            chk(dmarq_w === 1'b0, "R3 request held before ack", {31'b0, dmarq_w}, 0);
        end
        dmack_n = 1'b0;
        @(negedge clk);
        chk(dmarq_w === 1'b1, "R3 request drops after ack", {31'b0, dmarq_w}, 1);
        if (rd) begin
            ior_n = 1'b0;
            @(negedge clk);
            chk(dd_oe === 1'b1, "R4 bus driven", {31'b0, dd_oe}, 1);
            chk(dd_out === srcw(w), "R4 head word", {16'b0, dd_out}, {16'b0, srcw(w)});
            ior_n = 1'b1;
            @(negedge clk);
            chk(dd_oe === 1'b0, "R4 bus released", {31'b0, dd_oe}, 0);
            chk(src_idx == w + 1, "R4 pop count", src_idx, w + 1);
            if (extra) begin
                ior_n = 1'b0; @(negedge clk);
                ior_n = 1'b1; @(negedge clk);
                chk(src_idx == w + 1 && dd_oe === 1'b0, "R6 second read strobe ignored",
                    src_idx, w + 1);
            end
        end else begin
            if (extra) begin
                ior_n = 1'b0; @(negedge clk);
                chk(dd_oe === 1'b0, "R6 read strobe in write no drive", {31'b0, dd_oe}, 0);
                ior_n = 1'b1; @(negedge clk);
                chk(src_idx == 0, "R6 read strobe in write no pop", src_idx, 0);
            end
            dd_in = srcw(w + 100); iow_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
            iow_n = 1'b1; dd_in = ~srcw(w + 100);
            @(negedge clk);
            chk(push_cnt == w + 1, "R5 push count", push_cnt, w + 1);
            chk(last_push === srcw(w + 100), "R5 pushed word",
                {16'b0, last_push}, {16'b0, srcw(w + 100)});
            if (extra) begin
                dd_in = 16'h0F0F; iow_n = 1'b0; @(negedge clk);
                iow_n = 1'b1; @(negedge clk);
                chk(push_cnt == w + 1, "R6 second write strobe ignored", push_cnt, w + 1);
            end
        end
        dmack_n = 1'b1; src_gate = 1'b0; snk_gate = 1'b0;
    endtask

    task automatic run_xfer(input bit rd, input int len, input int ackd, input int stall);
        open_xfer(rd, len);
        if (len == 0) begin
            chk(done === 1'b1, "R7 zero length done", {31'b0, done}, 1);
            src_gate = 1'b1; snk_gate = 1'b1;
            repeat (3) @(negedge clk);
            chk(dmarq_w === 1'b1, "R7 zero length no request", {31'b0, dmarq_w}, 1);
            src_gate = 1'b0; snk_gate = 1'b0;
            return;
        end
        for (int w = 0; w < len; w++) begin
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                chk(dmarq_w === 1'b1, "R2 no request without FIFO room",
                    {31'b0, dmarq_w}, 1);
            end
            if (rd) src_gate = 1'b1; else snk_gate = 1'b1;
            @(negedge clk);
            wait_req(w == 0 ? "R2 request raised" : "R8 request raised again");
            one_word(rd, w, ackd, w == 0);
            @(negedge clk);
            chk(done === (w == len - 1), "R7 done after last word", {31'b0, done},
                {31'b0, w == len - 1});
        end
        src_gate = 1'b1; snk_gate = 1'b1;
        repeat (3) @(negedge clk);
        chk(dmarq_w === 1'b1, "R7 no request after done", {31'b0, dmarq_w}, 1);
        chk((rd ? src_idx : push_cnt) == len, "R7 total words",
            rd ? src_idx : push_cnt, len);
        src_gate = 1'b0; snk_gate = 1'b0;
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(dmarq_w === 1'b1 && dd_oe === 1'b0, "R1 reset outputs",
            {30'b0, dmarq_w, dd_oe}, 2);
        chk(done === 1'b0 && proto_err === 1'b0 && src_ready === 1'b0 &&
            snk_valid === 1'b0, "R1 reset flags",
            {28'b0, done, proto_err, src_ready, snk_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(dmarq_w === 1'b1 && done === 1'b0, "R1 idle after reset",
            {30'b0, dmarq_w, done}, 2);

        for (int rd = 0; rd < 2; rd++)
            for (int len = 0; len < 5; len++)
                run_xfer(rd[0], len, len % 3, (len + rd) % 3);

        // R9: chip select outside acknowledge, then at the write trailing edge
        open_xfer(1'b0, 1);
        cs0_n = 1'b0;
        @(negedge clk);
        chk(proto_err === 1'b0, "R9 no error outside ack", {31'b0, proto_err}, 0);
        cs0_n = 1'b1; snk_gate = 1'b1;
        wait_req("R2 request for error case");
        dmack_n = 1'b0;
        @(negedge clk);
        dd_in = 16'hBEEF; iow_n = 1'b0;
        @(negedge clk);
        iow_n = 1'b1; cs0_n = 1'b0; dd_in = 16'h0000;
        @(negedge clk);
        chk(proto_err === 1'b1, "R9 error flagged", {31'b0, proto_err}, 1);
        chk(push_cnt == 1 && last_push === 16'hBEEF, "R5 push alongside error",
            {16'b0, last_push}, 32'hBEEF);
        cs0_n = 1'b1; dmack_n = 1'b1; snk_gate = 1'b0;
        repeat (2) @(negedge clk);
        chk(proto_err === 1'b1 && done === 1'b1, "R9 error sticky",
            {30'b0, proto_err, done}, 3);
        open_xfer(1'b1, 0);
        chk(proto_err === 1'b0, "R9 cleared by start", {31'b0, proto_err}, 0);

        // R10: release of the request line when the other device is selected
        open_xfer(1'b1, 1);
        src_gate = 1'b1;
        wait_req("R10 request before deselect");
        drv_sel = 1'b1;
        #1;
        chk(dmarq_w === 1'b1, "R10 line released (pulled high)", {31'b0, dmarq_w}, 1);
        drv_sel = 1'b0;
        #1;
        chk(dmarq_w === 1'b0, "R10 line driven when selected", {31'b0, dmarq_w}, 0);
        one_word(1'b1, 0, 0, 1'b0);
        @(negedge clk);
        chk(done === 1'b1, "R7 done after deselect test", {31'b0, done}, 1);

        summary();
    end
endmodule